// File: doc/BRIEF.md
# Masked Channel Control Register

This block is the shared run-control word for a group of DMA channel engines. One 32-bit word carries, for every channel, a run-enable bit and a suspend-request bit. Each of those bits has a companion mask bit in the same word. A bus write changes a channel's bit only when its mask bit is 1 in that write. Two agents can therefore start, stop, pause or resume different channels with single writes, and no read-modify-write sequence is needed.

The registered enable and suspend levels drive the channel engines. An engine reports the end of its transfer, or an abort, and the block then drops that channel's enable on its own. A read shows which channels are still running. When an engine acknowledges a suspend request, the block emits a single one-cycle suspended event per suspend period, which goes to the interrupt status logic. A global controller-enable input gates every channel enable output without disturbing the stored state.

Field layout (bit i belongs to channel i, for up to 8 channels): run-enable at bits 7:0, run-enable mask at 15:8, suspend request at 23:16, suspend mask at 31:24.

Top module: `chan_ctl_reg`

## Requirements
- R1: After reset every channel enable output, suspend output and suspended event is 0, and the read word is 0.
- R2: A write (wr_en_i high) sets channel i's stored enable to wr_data_i[i] only when wr_data_i[8+i] is 1. Channels whose mask bit is 0 keep their value. The new value is visible on the outputs in the cycle after the write edge.
- R3: A write sets channel i's suspend request to wr_data_i[16+i] only when wr_data_i[24+i] is 1. Other suspend bits keep their value.
- R4: The read word shows the stored enable of channel i at bit i and its suspend request at bit 16+i. All mask positions (15:8, 31:24) and unused bits read as 0.
- R5: An engine done or abort pulse on channel i at a clock edge clears that channel's stored enable at that edge. It takes priority over a write setting the same bit in that cycle.
- R6: While ctrl_en_i is 0 all ch_en_o bits are 0, and the stored enables, as seen in the read word, are unchanged.
- R7: susp_evt_o[i] pulses for exactly one cycle, in the cycle after the first edge at which channel i's suspend request is 1 and eng_susp_ack_i[i] is 1. It does not pulse again until the suspend request has been cleared and set again.
- R8: A write with suspend bit i equal to 0 and suspend mask bit i equal to 1 (resume) clears ch_susp_o[i] in the next cycle.
- R9: When wr_en_i is 0, wr_data_i has no effect on any stored bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_en_i | input | 1 | Global controller enable; 0 forces all channel enables low |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Write data: values and their mask bits |
| rd_data_o | output | 32 | Live read word: stored enables and suspend requests |
| ch_en_o | output | NUM_CH | Per-channel run enable to the engines |
| ch_susp_o | output | NUM_CH | Per-channel suspend request to the engines |
| eng_done_i | input | NUM_CH | Engine transfer-complete pulse per channel |
| eng_abort_i | input | NUM_CH | Engine error-abort pulse per channel |
| eng_susp_ack_i | input | NUM_CH | Engine acknowledge that the channel is suspended |
| susp_evt_o | output | NUM_CH | One-cycle suspended event per channel |

## Verification
The masked write is driven with words whose value bits are all 1 but whose mask covers only some channels, and with words whose mask covers all channels but with mixed values. This tells a correct per-bit mask apart from a whole-field write or an inverted mask. Done and abort pulses are placed in the same cycle as a write that sets the same channel, which exposes the priority of the hardware clear. A suspend acknowledge is held high for many cycles, then suspend is dropped and raised again, to separate a one-shot event from a level and to show that the event re-arms. A long random phase with mixed writes, handshakes and controller-enable drops is compared every cycle against a behavioural model.

// File: rtl/chan_ctl_pkg.sv
package chan_ctl_pkg;
    localparam int WORD_W    = 32;
    localparam int FIELD_W   = 8;
    localparam int EN_LSB    = 0;
    localparam int EN_WE_LSB = EN_LSB + FIELD_W;
    localparam int SP_LSB    = EN_WE_LSB + FIELD_W;
    localparam int SP_WE_LSB = SP_LSB + FIELD_W;

    // Decoded per-channel write command
    typedef struct packed {
        logic en_we;
        logic en_val;
        logic sp_we;
        logic sp_val;
    } ch_cmd_t;

    // Per-channel registered state
    typedef struct packed {
        logic en;
        logic sp;
        logic rep;   // suspended event already reported this period
        logic evt;
    } ch_state_t;
endpackage

// File: rtl/chan_ctl_decode.sv
module chan_ctl_decode
    import chan_ctl_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                    wr_en_i,
    input  logic [WORD_W-1:0]       wr_data_i,
    output ch_cmd_t [NUM_CH-1:0]    cmd_o
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign cmd_o[g].en_we  = wr_en_i & wr_data_i[EN_WE_LSB + g];
        assign cmd_o[g].en_val = wr_data_i[EN_LSB + g];
        assign cmd_o[g].sp_we  = wr_en_i & wr_data_i[SP_WE_LSB + g];
        assign cmd_o[g].sp_val = wr_data_i[SP_LSB + g];
    end

    if (NUM_CH < FIELD_W) begin : g_unused
        logic unused_bits;
        assign unused_bits = ^{wr_data_i[EN_LSB + NUM_CH +: FIELD_W - NUM_CH],
                               wr_data_i[EN_WE_LSB + NUM_CH +: FIELD_W - NUM_CH],
                               wr_data_i[SP_LSB + NUM_CH +: FIELD_W - NUM_CH],
                               wr_data_i[SP_WE_LSB + NUM_CH +: FIELD_W - NUM_CH]};
    end
endmodule

// File: rtl/chan_ctl_slice.sv
module chan_ctl_slice
    import chan_ctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  ch_cmd_t cmd_i,
    input  logic    done_i,
    input  logic    abort_i,
    input  logic    ack_i,
    output logic    en_o,
    output logic    sp_o,
    output logic    evt_o
);
    ch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_i.en_we) begin
            st_d.en = cmd_i.en_val;
        end
        // hardware clear on idle wins over a software set
        if (done_i || abort_i) begin
            st_d.en = 1'b0;
        end
        if (cmd_i.sp_we) begin
            st_d.sp = cmd_i.sp_val;
        end
        st_d.evt = st_q.sp & ack_i & ~st_q.rep;
        st_d.rep = (st_q.rep | st_d.evt) & st_d.sp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o  = st_q.en;
    assign sp_o  = st_q.sp;
    assign evt_o = st_q.evt;
endmodule

// File: rtl/chan_ctl_reg.sv
module chan_ctl_reg
    import chan_ctl_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctrl_en_i,
    input  logic                wr_en_i,
    input  logic [31:0]         wr_data_i,
    output logic [31:0]         rd_data_o,
    output logic [NUM_CH-1:0]   ch_en_o,
    output logic [NUM_CH-1:0]   ch_susp_o,
    input  logic [NUM_CH-1:0]   eng_done_i,
    input  logic [NUM_CH-1:0]   eng_abort_i,
    input  logic [NUM_CH-1:0]   eng_susp_ack_i,
    output logic [NUM_CH-1:0]   susp_evt_o
);
    ch_cmd_t [NUM_CH-1:0] cmd;
    logic    [NUM_CH-1:0] en_q;
    logic    [NUM_CH-1:0] sp_q;

    chan_ctl_decode #(.NUM_CH(NUM_CH)) u_decode (
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .cmd_o     (cmd)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_slice
        chan_ctl_slice u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .cmd_i   (cmd[g]),
            .done_i  (eng_done_i[g]),
            .abort_i (eng_abort_i[g]),
            .ack_i   (eng_susp_ack_i[g]),
            .en_o    (en_q[g]),
            .sp_o    (sp_q[g]),
            .evt_o   (susp_evt_o[g])
        );
    end

    always_comb begin
        rd_data_o = '0;
        rd_data_o[EN_LSB +: NUM_CH] = en_q;
        rd_data_o[SP_LSB +: NUM_CH] = sp_q;
    end

    assign ch_en_o   = en_q & {NUM_CH{ctrl_en_i}};
    assign ch_susp_o = sp_q;
endmodule

// File: rtl/chan_ctl_reg_chk.sv
module chan_ctl_reg_chk
    import chan_ctl_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ctrl_en_i,
    input logic                wr_en_i,
    input logic [31:0]         wr_data_i,
    input logic [31:0]         rd_data_o,
    input logic [NUM_CH-1:0]   ch_en_o,
    input logic [NUM_CH-1:0]   ch_susp_o,
    input logic [NUM_CH-1:0]   eng_done_i,
    input logic [NUM_CH-1:0]   eng_abort_i,
    input logic [NUM_CH-1:0]   eng_susp_ack_i,
    input logic [NUM_CH-1:0]   susp_evt_o
);
    p_masked_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_data_o[EN_LSB +: NUM_CH] ^ $past(wr_data_i[EN_LSB +: NUM_CH]))
         & $past(wr_data_i[EN_WE_LSB +: NUM_CH]) & {NUM_CH{$past(wr_en_i)}}
         & ~$past(eng_done_i | eng_abort_i)) == '0);

    p_masked_sp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((ch_susp_o ^ $past(wr_data_i[SP_LSB +: NUM_CH]))
         & $past(wr_data_i[SP_WE_LSB +: NUM_CH]) & {NUM_CH{$past(wr_en_i)}}) == '0);

    p_we_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[EN_WE_LSB +: FIELD_W] == '0 && rd_data_o[SP_WE_LSB +: FIELD_W] == '0);

    p_idle_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o[EN_LSB +: NUM_CH] & $past(eng_done_i | eng_abort_i)) == '0);

    p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en_i |-> ch_en_o == '0);

    p_out_subset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en_o & ~rd_data_o[EN_LSB +: NUM_CH]) == '0);

    p_evt_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_evt_o & ~$past(ch_susp_o & eng_susp_ack_i)) == '0);

    p_evt_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_evt_o & $past(susp_evt_o)) == '0);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en_i) && $past(eng_done_i | eng_abort_i) == '0)
        |-> $stable(rd_data_o));
endmodule

bind chan_ctl_reg chan_ctl_reg_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctrl_en_i      (ctrl_en_i),
    .wr_en_i        (wr_en_i),
    .wr_data_i      (wr_data_i),
    .rd_data_o      (rd_data_o),
    .ch_en_o        (ch_en_o),
    .ch_susp_o      (ch_susp_o),
    .eng_done_i     (eng_done_i),
    .eng_abort_i    (eng_abort_i),
    .eng_susp_ack_i (eng_susp_ack_i),
    .susp_evt_o     (susp_evt_o)
);

// File: tb/tb_chan_ctl_reg.sv
module tb_chan_ctl_reg;
    localparam int  N     = 8;
    localparam time CLK_P = 8ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ctrl_en_i = 1'b1;
    logic         wr_en_i = 1'b0;
    logic [31:0]  wr_data_i = '0;
    logic [31:0]  rd_data_o;
    logic [N-1:0] ch_en_o, ch_susp_o, susp_evt_o;
    logic [N-1:0] eng_done_i = '0, eng_abort_i = '0, eng_susp_ack_i = '0;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;
    string phase = "R1";

    // behavioural reference state
    bit m_en [N];
    bit m_sp [N];
    bit m_rep[N];
    bit m_evt[N];

    chan_ctl_reg #(.NUM_CH(N)) dut (
        .clk(clk), .rst_n(rst_n), .ctrl_en_i(ctrl_en_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
        .ch_en_o(ch_en_o), .ch_susp_o(ch_susp_o),
        .eng_done_i(eng_done_i), .eng_abort_i(eng_abort_i),
        .eng_susp_ack_i(eng_susp_ack_i), .susp_evt_o(susp_evt_o)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            bit ne, ns, nv;
            if (!rst_n) begin
                m_en[i] = 0; m_sp[i] = 0; m_rep[i] = 0; m_evt[i] = 0;
            end else begin
                ne = m_en[i];
                if (wr_en_i && wr_data_i[8+i]) ne = wr_data_i[i];
                if (eng_done_i[i] || eng_abort_i[i]) ne = 0;
                ns = m_sp[i];
                if (wr_en_i && wr_data_i[24+i]) ns = wr_data_i[16+i];
                nv = m_sp[i] && eng_susp_ack_i[i] && !m_rep[i];
                m_rep[i] = (m_rep[i] || nv) && ns;
                m_evt[i] = nv;
                m_en[i]  = ne;
                m_sp[i]  = ns;
            end
        end
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare_model();
        logic [31:0]  e_rd = '0;
        logic [N-1:0] e_en, e_sp, e_ev;
        for (int i = 0; i < N; i++) begin
            e_rd[i]    = m_en[i];
            e_rd[16+i] = m_sp[i];
            e_sp[i]    = m_sp[i];
            e_ev[i]    = m_evt[i];
            e_en[i]    = m_en[i] & ctrl_en_i;
        end
        check(phase, "rd_data (R4)", rd_data_o, e_rd);
        check(phase, "ch_en", 32'(ch_en_o), 32'(e_en));
        check(phase, "ch_susp", 32'(ch_susp_o), 32'(e_sp));
        check(phase, "susp_evt (R7)", 32'(susp_evt_o), 32'(e_ev));
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        compare_model();
    endtask

    task automatic write(logic [31:0] d);
        wr_en_i = 1'b1;
        wr_data_i = d;
        tick();
        wr_en_i = 1'b0;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1", "rd after reset", rd_data_o, 32'h0);
        check("R1", "outputs after reset", 32'({ch_en_o, ch_susp_o, susp_evt_o}), 32'h0);

        // R2 partial mask: values all 1, mask only ch0 and ch2
        phase = "R2";
        write(32'h0000_05FF);
        check("R2", "masked set", 32'(ch_en_o), 32'h05);
        // R2 mask covers ch2 only with value 0
        write(32'h0000_0400);
        check("R2", "masked clear", 32'(ch_en_o), 32'h01);

        // R9 data with strobe low
        phase = "R9";
        wr_data_i = 32'hFFFF_FFFF;
        tick();
        tick();
        check("R9", "no strobe no change", rd_data_o, 32'h0000_0001);

        // R6 global gate
        phase = "R6";
        ctrl_en_i = 1'b0;
        tick();
        check("R6", "gated outputs", 32'(ch_en_o), 32'h0);
        check("R6", "stored kept", rd_data_o, 32'h0000_0001);
        ctrl_en_i = 1'b1;
        tick();

        // R5 done clears; abort beats a simultaneous set
        phase = "R5";
        write(32'h0000_2828);
        check("R5", "ch3 ch5 set", 32'(ch_en_o), 32'h29);
        eng_done_i = 8'h08;
        tick();
        eng_done_i = '0;
        check("R5", "done clears ch3", 32'(ch_en_o), 32'h21);
        eng_abort_i = 8'h40;
        write(32'h0000_4040);
        eng_abort_i = '0;
        check("R5", "abort wins over set", 32'(ch_en_o), 32'h21);

        // R3 suspend ch0 and ch4 with value bits for others ignored
        phase = "R3";
        write(32'h1100_FF00 | 32'h00FF_0000);
        check("R3", "masked suspend", 32'(ch_susp_o), 32'h11);
        check("R2", "mask all clears", 32'(ch_en_o), 32'h00);

        // R7 one-shot event with ack held
        phase = "R7";
        eng_susp_ack_i = 8'h01;
        tick();
        check("R7", "event pulse", 32'(susp_evt_o), 32'h01);
        tick();
        check("R7", "event single", 32'(susp_evt_o), 32'h00);
        repeat (4) tick();
        check("R7", "no repeat", 32'(susp_evt_o), 32'h00);

        // R8 resume ch0
        phase = "R8";
        write(32'h0100_0000);
        check("R8", "resume clears", 32'(ch_susp_o), 32'h10);
        // re-arm: suspend again with ack still high
        phase = "R7";
        write(32'h0101_0000);
        check("R7", "suspend again", 32'(ch_susp_o), 32'h11);
        tick();
        check("R7", "event re-armed", 32'(susp_evt_o), 32'h01);
        eng_susp_ack_i = '0;
        tick();

        // mixed random traffic vs model
        phase = "R2/R3/R5/R7 random";
        for (int k = 0; k < 2000; k++) begin
            wr_en_i        = ($urandom_range(0, 3) == 0);
            wr_data_i      = $urandom;
            eng_done_i     = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
            eng_abort_i    = ($urandom_range(0, 7) == 0) ? N'($urandom) : '0;
            eng_susp_ack_i = N'($urandom);
            ctrl_en_i      = ($urandom_range(0, 9) != 0);
            tick();
        end

        finished = 1;
        summary();
        $finish;
    end
endmodule